// File: doc/BRIEF.md
# Pixel Clock and Half-Pixel Phase Generator

This block sits next to a video encoder and runs from a 21.47727 MHz master clock. It turns a two-bit select field into a one-cycle pixel enable at one quarter, one third or one half of the master rate. It also keeps count of scanlines and frames, using the horizontal and vertical sync strobes from the video controller.

From those counts it keeps a pixel-shift flip-flop and a half-pixel-shift flag. While the long-frame control bit is set, the flip-flop inverts once per frame. The flag tells the output stage whether the current scanline is offset by half a pixel. The flag is the XOR of frame parity, line parity and the pixel-shift state. One clock setting leaves frame parity out of that XOR.

A frame normally starts on the vertical sync strobe. If no vertical strobe arrives, the line counter starts a new frame by itself once the frame holds its full count of lines. That count is 262 or 263, chosen by the long-frame bit.

Top module: `pixel_phase_gen`

## Requirements
- R1: The pixel enable repeats with a period set by `clkSel`: 4 master cycles for 2'b00, 3 for 2'b01, and 2 for both 2'b10 and 2'b11.
- R2: The pixel enable is high for exactly one master cycle per period.
- R3: When `clkSel` changes, the divider restarts. Counting the clock edge that first samples the new value as edge 0, the first pixel enable appears after edge N, where N is the new period.
- R4: The line count goes up on each horizontal strobe. A vertical strobe sets the line count to 0 and advances the frame count. Both changes show up in the parity terms of `halfShift`.
- R5: Suppose no vertical strobe arrives. After 262 lines with `longFrame`=0, or 263 lines with `longFrame`=1, the next horizontal strobe starts a new frame in exactly the way a vertical strobe does.
- R6: At each frame start, `shiftState` inverts if `longFrame` is 1. If `longFrame` is 0, `shiftState` keeps its value.
- R7: At each line start, `halfShift` becomes frame-count LSB XOR line-count LSB XOR `shiftState`, using the values of the new line.
- R8: When `clkSel`=2'b11 and `longFrame`=0 at a line start, the frame-count LSB is left out of the R7 XOR.
- R9: `halfShift` and `shiftState` change only on the clock edge that samples a strobe. They stay constant through the line, even if `clkSel` or `longFrame` changes during the line.
- R10: Reset (active-low `rstN`) clears the line count, the frame count and `shiftState`. While in reset, `pixEn`=0 and `halfShift`=0.
- R11: When a horizontal and a vertical strobe come in the same cycle, the vertical strobe wins: the line count goes to 0 and a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 21.47727 MHz master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 2 | Pixel clock select (00 /4, 01 /3, 1x /2) |
| longFrame | input | 1 | 1: 263-line frame and per-frame shift toggle; 0: 262-line frame |
| hsyncStb | input | 1 | One-cycle horizontal sync strobe (line start) |
| vsyncStb | input | 1 | One-cycle vertical sync strobe (frame start) |
| pixEn | output | 1 | One-cycle pixel clock enable |
| shiftState | output | 1 | Per-frame pixel-shift flip-flop |
| halfShift | output | 1 | Half-pixel offset flag for the current scanline |

## Verification
Some properties are checked by assertions on every cycle:
- the one-cycle width of the pixel enable;
- an upper bound on the gap between enables;
- `halfShift` and `shiftState` holding steady between strobes;
- the shift flip-flop inverting or holding at a vertical strobe;
- the line-parity-only result under setting 3 at a vertical strobe.

Other properties need the bench's scenarios, because each one needs a reference model of the counts across a whole sequence:
- the exact period for each select value;
- the restart delay after a select change;
- the value of `halfShift` on every line across several frames;
- the frame wraps at 262 and 263 lines;
- the precedence of the vertical strobe over the horizontal one.

// File: rtl/pixel_phase_pkg.sv
package pixel_phase_pkg;

  localparam int SEL_W = 2;
  localparam int DIV_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_QUARTER = 2'b00,
    SEL_THIRD   = 2'b01,
    SEL_HALF_A  = 2'b10,
    SEL_HALF_B  = 2'b11
  } pixSel_e;

  // Strobes and next-line values handed from control to datapath
  typedef struct packed {
    logic lineStart;
    logic frameLsb;
    logic lineLsb;
    logic shiftNext;
  } phaseStb_t;

  // Terminal count of the divider for a select value (period - 1)
  function automatic logic [DIV_W-1:0] divLimit(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] lim;
    case (sel)
      SEL_QUARTER: lim = DIV_W'(3);
      SEL_THIRD:   lim = DIV_W'(2);
      default:     lim = DIV_W'(1);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/pixel_phase_div.sv
module pixel_phase_div
  import pixel_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  output logic             pixEn
);

  logic [SEL_W-1:0] selPrev;
  logic [DIV_W-1:0] divCnt;
  logic             selChange;
  logic             atLimit;

  assign selChange = (clkSel != selPrev);
  assign atLimit   = (divCnt == divLimit(clkSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= '0;
      divCnt  <= '0;
      pixEn   <= 1'b0;
    end else begin
      selPrev <= clkSel;
      if (selChange) begin
        divCnt <= '0;
        pixEn  <= 1'b0;
      end else if (atLimit) begin
        divCnt <= '0;
        pixEn  <= 1'b1;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
        pixEn  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pixel_phase_ctrl.sv
module pixel_phase_ctrl
  import pixel_phase_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int FRAME_W     = 8,
  parameter int SHORT_LINES = 262,
  parameter int LONG_LINES  = 263
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      longFrame,
  input  logic      hsyncStb,
  input  logic      vsyncStb,
  output phaseStb_t stb,
  output logic      shiftState
);

  localparam logic [LINE_W-1:0] SHORT_LAST = LINE_W'(SHORT_LINES - 1);
  localparam logic [LINE_W-1:0] LONG_LAST  = LINE_W'(LONG_LINES - 1);

  logic [LINE_W-1:0]  lineCnt, lineNext, lastLine;
  logic [FRAME_W-1:0] frameCnt, frameNext;
  logic               shiftNext;
  logic               lineStart, frameStart, wrapHit;

  always_comb begin
    lastLine   = longFrame ? LONG_LAST : SHORT_LAST;
    wrapHit    = hsyncStb && (lineCnt >= lastLine);
    frameStart = vsyncStb || wrapHit;
    lineStart  = hsyncStb || vsyncStb;

    if (frameStart)     lineNext = '0;
    else if (lineStart) lineNext = lineCnt + LINE_W'(1);
    else                lineNext = lineCnt;

    frameNext = frameStart ? frameCnt + FRAME_W'(1) : frameCnt;
    shiftNext = shiftState ^ (frameStart && longFrame);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt    <= '0;
      frameCnt   <= '0;
      shiftState <= 1'b0;
    end else begin
      lineCnt    <= lineNext;
      frameCnt   <= frameNext;
      shiftState <= shiftNext;
    end
  end

  always_comb begin
    stb.lineStart = lineStart;
    stb.frameLsb  = frameNext[0];
    stb.lineLsb   = lineNext[0];
    stb.shiftNext = shiftNext;
  end

endmodule

// File: rtl/pixel_phase_dp.sv
module pixel_phase_dp
  import pixel_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             longFrame,
  input  phaseStb_t        stb,
  output logic             halfShift
);

  logic dropParity;
  logic halfNext;

  assign dropParity = (clkSel == SEL_HALF_B) && !longFrame;
  assign halfNext   = (stb.frameLsb && !dropParity) ^ stb.lineLsb ^ stb.shiftNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              halfShift <= 1'b0;
    else if (stb.lineStart) halfShift <= halfNext;
  end

endmodule

// File: rtl/pixel_phase_gen.sv
module pixel_phase_gen
  import pixel_phase_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int FRAME_W     = 8,
  parameter int SHORT_LINES = 262,
  parameter int LONG_LINES  = 263
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkSel,
  input  logic       longFrame,
  input  logic       hsyncStb,
  input  logic       vsyncStb,
  output logic       pixEn,
  output logic       shiftState,
  output logic       halfShift
);

  phaseStb_t stb;

  pixel_phase_div u_div (
    .clk    (clk),
    .rstN   (rstN),
    .clkSel (clkSel),
    .pixEn  (pixEn)
  );

  pixel_phase_ctrl #(
    .LINE_W      (LINE_W),
    .FRAME_W     (FRAME_W),
    .SHORT_LINES (SHORT_LINES),
    .LONG_LINES  (LONG_LINES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .longFrame  (longFrame),
    .hsyncStb   (hsyncStb),
    .vsyncStb   (vsyncStb),
    .stb        (stb),
    .shiftState (shiftState)
  );

  pixel_phase_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .clkSel    (clkSel),
    .longFrame (longFrame),
    .stb       (stb),
    .halfShift (halfShift)
  );

endmodule

// File: rtl/pixel_phase_chk.sv
module pixel_phase_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] clkSel,
  input logic       longFrame,
  input logic       hsyncStb,
  input logic       vsyncStb,
  input logic       pixEn,
  input logic       shiftState,
  input logic       halfShift
);

  logic [1:0] selSeen;
  logic [3:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSeen <= 2'b00;
      gapCnt  <= '0;
    end else begin
      selSeen <= clkSel;
      if (pixEn || clkSel != selSeen) gapCnt <= '0;
      else                            gapCnt <= gapCnt + 4'd1;
    end
  end

  // R1
  pix_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= 4'd4);

  // R2
  pix_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixEn |=> !pixEn);

  // R9
  half_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hsyncStb || vsyncStb) |=> $stable(halfShift) && $stable(shiftState));

  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !longFrame |=> $stable(shiftState));

  // R6
  shift_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncStb && longFrame) |=> (shiftState != $past(shiftState)));

  // R8
  set3_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncStb && !longFrame && clkSel == 2'b11) |=> (halfShift == shiftState));

endmodule

bind pixel_phase_gen pixel_phase_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkSel     (clkSel),
  .longFrame  (longFrame),
  .hsyncStb   (hsyncStb),
  .vsyncStb   (vsyncStb),
  .pixEn      (pixEn),
  .shiftState (shiftState),
  .halfShift  (halfShift)
);

// File: tb/pixel_phase_gen_tb.sv
module pixel_phase_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] clkSel = 2'b00;
  logic       longFrame = 1'b0;
  logic       hsyncStb = 1'b0;
  logic       vsyncStb = 1'b0;
  logic       pixEn, shiftState, halfShift;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string tag;
    logic  half;
    logic  shift;
  } expItem_t;

  expItem_t expQ[$];

  // reference model state
  int   mLine  = 0;
  logic mFrame = 1'b0;
  logic mShift = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_phase_gen u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .clkSel     (clkSel),
    .longFrame  (longFrame),
    .hsyncStb   (hsyncStb),
    .vsyncStb   (vsyncStb),
    .pixEn      (pixEn),
    .shiftState (shiftState),
    .halfShift  (halfShift)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int periodOf(input logic [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 3 : 2;
  endfunction

  task automatic newFrame();
    mLine  = 0;
    mFrame = ~mFrame;
    if (longFrame) mShift = ~mShift;
  endtask

  // driver: one line-start event, expected result pushed to the scoreboard
  task automatic lineEvt(input bit hs, input bit vs, input string tag);
    expItem_t it;
    int lastLine;
    @(negedge clk);
    lastLine = longFrame ? 262 : 261;
    if (vs)                       newFrame();
    else if (mLine >= lastLine)   newFrame();
    else                          mLine++;
    it.tag   = tag;
    it.shift = mShift;
    it.half  = ((clkSel == 2'b11 && !longFrame) ? 1'b0 : mFrame) ^ mLine[0] ^ mShift;
    expQ.push_back(it);
    hsyncStb = hs;
    vsyncStb = vs;
    @(negedge clk);
    hsyncStb = 1'b0;
    vsyncStb = 1'b0;
  endtask

  // monitor: after each strobe edge, pop and compare
  initial begin
    forever begin
      bit saw;
      expItem_t it;
      @(posedge clk);
      saw = hsyncStb || vsyncStb;
      #(CLK_PERIOD/4);
      if (saw && rstN) begin
        if (expQ.size() == 0) begin
          check(0, "scoreboard underflow", 0, 1);
        end else begin
          it = expQ.pop_front();
          check(halfShift == it.half,  {it.tag, " halfShift"}, halfShift, it.half);
          check(shiftState == it.shift, {it.tag, " shiftState"}, shiftState, it.shift);
        end
      end
    end
  end

  // R1 R2 R3: new select, first pulse timing, width, steady period
  task automatic pixTest(input logic [1:0] s);
    int n;
    int per;
    per = periodOf(s);
    @(negedge clk);
    clkSel = s;
    n = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (pixEn) begin n = i; break; end
    end
    check(n == per + 1, "R3 first pulse after select change", n, per + 1);
    @(negedge clk);
    check(pixEn == 1'b0, "R2 pulse width one cycle", pixEn, 0);
    n = 1;
    for (int i = 2; i <= 10; i++) begin
      @(negedge clk);
      if (pixEn) begin n = i; break; end
    end
    check(n == per, "R1 pixel period", n, per);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pixEn == 1'b0, "R10 reset pixEn", pixEn, 0);
    check(shiftState == 1'b0, "R10 reset shiftState", shiftState, 0);
    check(halfShift == 1'b0, "R10 reset halfShift", halfShift, 0);
    rstN = 1'b1;

    // divider under every select, including a mid-count restart
    pixTest(2'b01);
    pixTest(2'b10);
    pixTest(2'b00);
    pixTest(2'b11);
    repeat (2) @(negedge clk);
    pixTest(2'b00);

    // R4 R7: short frames, no toggle
    longFrame = 1'b0;
    lineEvt(1, 0, "R4 hsync first line");
    lineEvt(1, 0, "R7 line parity");
    lineEvt(0, 1, "R4 vsync resets line");
    for (int i = 0; i < 5; i++) lineEvt(1, 0, "R7 lines frame 1");
    lineEvt(0, 1, "R6 hold with longFrame 0");

    // R6: toggle across frames
    longFrame = 1'b1;
    for (int f = 0; f < 3; f++) begin
      lineEvt(0, 1, "R6 toggle at frame");
      lineEvt(1, 0, "R7 toggled line a");
      lineEvt(1, 0, "R7 toggled line b");
    end

    // R8: setting 3 drops frame parity
    longFrame = 1'b0;
    clkSel = 2'b11;
    for (int f = 0; f < 2; f++) begin
      lineEvt(0, 1, "R8 set3 frame start");
      lineEvt(1, 0, "R8 set3 line");
      lineEvt(1, 0, "R8 set3 line");
    end

    // R9: mid-line control changes leave the flag untouched
    begin
      logic h0;
      logic s0;
      clkSel = 2'b00;
      lineEvt(1, 0, "R9 line before change");
      h0 = halfShift;
      s0 = shiftState;
      @(negedge clk);
      clkSel = 2'b11;
      longFrame = 1'b1;
      repeat (4) @(negedge clk);
      check(halfShift == h0, "R9 halfShift stable mid-line", halfShift, h0);
      check(shiftState == s0, "R9 shiftState stable mid-line", shiftState, s0);
      clkSel = 2'b00;
      longFrame = 1'b0;
    end

    // R11: simultaneous strobes
    lineEvt(1, 0, "R11 setup line");
    lineEvt(1, 1, "R11 vsync wins");
    lineEvt(1, 0, "R11 following line");

    // R5: flywheel wrap at 262 and 263 lines
    longFrame = 1'b0;
    lineEvt(0, 1, "R5 short frame start");
    for (int i = 0; i < 264; i++) lineEvt(1, 0, "R5 short frame line");
    longFrame = 1'b1;
    lineEvt(0, 1, "R5 long frame start");
    for (int i = 0; i < 265; i++) lineEvt(1, 0, "R5 long frame line");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule